// File: doc/BRIEF.md
# Configurable Serial Sample Output Formatter

This block turns 12-bit parallel sample words into a serial bit stream on one data line. It runs entirely from a fast clock that ticks twelve times per serial bit period. Alongside the data it produces a forwarded bit clock and a frame marker, so a receiver can recover both bit and word alignment. Frames follow each other back to back, and one sample word is taken per frame.

Four settings shape the stream: the serial word length (8, 10, 12 or 14 bit periods), the bit order, data inversion, and the phase of the forwarded clock. The phase is set in 60-degree steps, with a 90-degree offset from the data edge as the base. All settings and the sample word are captured together at the end of each frame. A word therefore always goes out complete and with one consistent set of settings, whenever the inputs change.

All three outputs are registered. Each one lags the internal bit-timing state by one fast-clock cycle.

Top module: `serial_frame_fmt`

## Requirements
- R1: While reset is high, all three outputs are low. The first frame after reset is 12 bits long, MSB first, not inverted, with the default clock phase, and it carries an all-zero word.
- R2: A bit period lasts exactly 12 fast-clock cycles. The serial data changes only in the first cycle of a bit period, which is the cycle in which the frame marker rises at the start of a frame.
- R3: The frame length in bit periods follows `len_sel_i`: 0 gives 8, 1 gives 10, 2 gives 12 and 3 gives 14. The next frame starts right after the last bit period of the current one.
- R4: With MSB-first order and a length of 8, 10 or 12, frame bit k carries sample bit 11-k. The shortened lengths keep the upper sample bits and drop the lower ones.
- R5: With a length of 14, frame bits 0 to 11 carry the 12 sample bits and frame bits 12 and 13 are stuffed zeros, before any inversion.
- R6: With `lsb_first_i` high, the kept sample bits are sent in reverse order, starting with the lowest kept bit (sample bit 4, 2 or 0 for lengths 8, 10 and 12/14). The stuffed zeros of the 14-bit length stay at the end.
- R7: With `invert_i` high, every frame bit is complemented, stuffed bits included. This works with either bit order.
- R8: The forwarded clock has a period of one bit period and a 50% duty cycle. It is high in the 6 fast cycles that start (3 + 2*p) mod 12 cycles after the data edge, where p is `phase_sel_i`. This gives 90 + 60*p degrees, so settings 6 and 7 repeat settings 0 and 1.
- R9: The frame marker is high during the first half of the frame's bit periods and low during the second half.
- R10: The settings and the sample are captured only in the last fast-clock cycle of a frame. A change at any other time does not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 12 cycles per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 12 | Parallel sample word, captured at the frame boundary |
| len_sel_i | input | 2 | Serial word length select (8/10/12/14) |
| lsb_first_i | input | 1 | Send the lowest kept bit first |
| invert_i | input | 1 | Complement every output data bit |
| phase_sel_i | input | 3 | Forwarded clock phase step, 60 degrees each |
| sdata_o | output | 1 | Serial data bit |
| fclk_o | output | 1 | Forwarded bit clock |
| frame_o | output | 1 | Frame marker, high for the first half of each frame |

## Verification
The hardest case to reach from the ports is a settings change that arrives while a frame is in progress. The block must ignore it until the boundary, including a length change that would otherwise cut the frame short or move its end. For every setting combination, the stimulus waits until a frame's marker rises and loads the settings under test, so that they apply to the following frame. Halfway through that checked frame it drives a different length, order, inversion, phase and sample. Any bit, clock or marker that goes wrong in the second half of the frame, or an end of frame that comes at the wrong cycle, shows a capture that happened too early.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;

  typedef enum logic [1:0] {
    LEN_8  = 2'd0,
    LEN_10 = 2'd1,
    LEN_12 = 2'd2,
    LEN_14 = 2'd3
  } len_e;

  // number of bit periods in a frame for a given length code
  function automatic int frame_bits(input len_e l, input int sample_w);
    case (l)
      LEN_8:   return sample_w - 4;
      LEN_10:  return sample_w - 2;
      LEN_12:  return sample_w;
      default: return sample_w + 2;
    endcase
  endfunction

  // number of sample bits actually carried in a frame
  function automatic int data_bits(input len_e l, input int sample_w);
    int n;
    n = frame_bits(l, sample_w);
    return (n < sample_w) ? n : sample_w;
  endfunction

endpackage

// File: rtl/sfmt_timing.sv
module sfmt_timing #(
  parameter int TICKS    = 12,
  parameter int MAX_BITS = 14,
  localparam int TICK_W  = $clog2(TICKS),
  localparam int BIT_W   = $clog2(MAX_BITS),
  localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  len_i,
  output logic [TICK_W-1:0] tick_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              last_o
);

  logic [TICK_W-1:0] tick_q;
  logic [BIT_W-1:0]  bit_q;
  logic              tick_end;
  logic              bit_end;

  assign tick_end = (tick_q == TICK_W'(TICKS - 1));
  assign bit_end  = (int'(bit_q) == int'(len_i) - 1);
  assign last_o   = tick_end && bit_end;
  assign tick_o   = tick_q;
  assign bit_o    = bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      bit_q  <= '0;
    end else if (tick_end) begin
      tick_q <= '0;
      bit_q  <= bit_end ? '0 : bit_q + 1'b1;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  // R3: the bit position never runs past the active frame length
  p_bit_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
    int'(bit_q) < int'(len_i));

  // R2: the bit position only moves when the tick counter wraps
  p_bit_step_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(tick_q) != TICK_W'(TICKS - 1)) |-> $stable(bit_q));

endmodule

// File: rtl/sfmt_capture.sv
module sfmt_capture
  import sfmt_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int PH_W     = 3,
  localparam int MAX_BITS = SAMPLE_W + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  len_e                len_i,
  input  logic                lsb_i,
  input  logic                inv_i,
  input  logic [PH_W-1:0]     phase_i,
  output len_e                len_o,
  output logic                inv_o,
  output logic [PH_W-1:0]     phase_o,
  output logic [MAX_BITS-1:0] pattern_o
);

  logic [MAX_BITS-1:0] msb_pat;
  logic [MAX_BITS-1:0] lsb_pat;
  logic [MAX_BITS-1:0] pat_d;
  int                  nd;

  len_e                len_q;
  logic                inv_q;
  logic [PH_W-1:0]     phase_q;
  logic [MAX_BITS-1:0] pat_q;

  // MSB-first order does not depend on the length: unused tail is never sent
  for (genvar k = 0; k < MAX_BITS; k++) begin : g_msb
    if (k < SAMPLE_W) begin : g_data
      assign msb_pat[k] = sample_i[SAMPLE_W-1-k];
    end else begin : g_stuff
      assign msb_pat[k] = 1'b0;
    end
  end

  // LSB-first: reverse the kept upper bits, stuffing stays at the tail
  always_comb begin
    nd      = data_bits(len_i, SAMPLE_W);
    lsb_pat = '0;
    for (int k = 0; k < MAX_BITS; k++) begin
      if (k < nd) lsb_pat[k] = sample_i[SAMPLE_W - nd + k];
    end
  end

  assign pat_d = lsb_i ? lsb_pat : msb_pat;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q   <= LEN_12;
      inv_q   <= 1'b0;
      phase_q <= '0;
      pat_q   <= '0;
    end else if (load_i) begin
      len_q   <= len_i;
      inv_q   <= inv_i;
      phase_q <= phase_i;
      pat_q   <= pat_d;
    end
  end

  assign len_o     = len_q;
  assign inv_o     = inv_q;
  assign phase_o   = phase_q;
  assign pattern_o = pat_q;

  // R10: captured settings and word hold still between frame boundaries
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(load_i) |-> ($stable(len_q) && $stable(inv_q) && $stable(phase_q) && $stable(pat_q)));

endmodule

// File: rtl/sfmt_serial.sv
module sfmt_serial #(
  parameter int MAX_BITS = 14,
  localparam int BIT_W   = $clog2(MAX_BITS),
  localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [MAX_BITS-1:0] pattern_i,
  input  logic [BIT_W-1:0]    bit_i,
  input  logic [CNT_W-1:0]    len_i,
  input  logic                inv_i,
  output logic                sdata_o,
  output logic                frame_o
);

  logic sdata_q;
  logic frame_q;
  logic bit_val;
  logic first_half;

  assign bit_val    = (int'(bit_i) < MAX_BITS) ? pattern_i[bit_i] : 1'b0;
  assign first_half = (int'(bit_i) < (int'(len_i) / 2));

  always_ff @(posedge clk) begin
    if (rst) begin
      sdata_q <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      sdata_q <= bit_val ^ inv_i;
      frame_q <= first_half;
    end
  end

  assign sdata_o = sdata_q;
  assign frame_o = frame_q;

  // R9: the marker only rises on the first bit of a frame
  p_frame_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_q) |-> ($past(bit_i) == '0));

endmodule

// File: rtl/sfmt_fwd_clk.sv
module sfmt_fwd_clk #(
  parameter int TICKS      = 12,
  parameter int PH_W       = 3,
  parameter int BASE_TICKS = TICKS / 4,
  parameter int STEP_TICKS = TICKS / 6,
  localparam int TICK_W    = $clog2(TICKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TICK_W-1:0] tick_i,
  input  logic [PH_W-1:0]   phase_i,
  output logic              fclk_o
);

  logic [TICK_W-1:0] off_w;
  logic [TICK_W-1:0] rel_w;
  logic              fclk_q;

  always_comb begin
    off_w = TICK_W'((BASE_TICKS + STEP_TICKS * int'(phase_i)) % TICKS);
    if (tick_i >= off_w) rel_w = tick_i - off_w;
    else                 rel_w = TICK_W'(int'(tick_i) + TICKS - int'(off_w));
  end

  always_ff @(posedge clk) begin
    if (rst) fclk_q <= 1'b0;
    else     fclk_q <= (int'(rel_w) < TICKS / 2);
  end

  assign fclk_o = fclk_q;

  // R8: inside a bit period the clock rises only at the selected offset
  p_fclk_rise_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(fclk_q) && ($past(tick_i) != '0)) |-> ($past(tick_i) == $past(off_w)));

endmodule

// File: rtl/serial_frame_fmt.sv
module serial_frame_fmt
  import sfmt_pkg::*;
#(
  parameter int SAMPLE_W      = 12,
  parameter int TICKS_PER_BIT = 12,
  parameter int PH_W          = 3,
  localparam int MAX_BITS     = SAMPLE_W + 2,
  localparam int TICK_W       = $clog2(TICKS_PER_BIT),
  localparam int BIT_W        = $clog2(MAX_BITS),
  localparam int CNT_W        = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [1:0]          len_sel_i,
  input  logic                lsb_first_i,
  input  logic                invert_i,
  input  logic [PH_W-1:0]     phase_sel_i,
  output logic                sdata_o,
  output logic                fclk_o,
  output logic                frame_o
);

  logic [TICK_W-1:0]   tick_q;
  logic [BIT_W-1:0]    bit_q;
  logic                frame_last;
  len_e                len_act;
  logic                inv_act;
  logic [PH_W-1:0]     phase_act;
  logic [MAX_BITS-1:0] pattern;
  logic [CNT_W-1:0]    len_bits;

  assign len_bits = CNT_W'(frame_bits(len_act, SAMPLE_W));

  sfmt_timing #(
    .TICKS    (TICKS_PER_BIT),
    .MAX_BITS (MAX_BITS)
  ) u_timing (
    .clk    (clk),
    .rst    (rst),
    .len_i  (len_bits),
    .tick_o (tick_q),
    .bit_o  (bit_q),
    .last_o (frame_last)
  );

  sfmt_capture #(
    .SAMPLE_W (SAMPLE_W),
    .PH_W     (PH_W)
  ) u_capture (
    .clk       (clk),
    .rst       (rst),
    .load_i    (frame_last),
    .sample_i  (sample_i),
    .len_i     (len_e'(len_sel_i)),
    .lsb_i     (lsb_first_i),
    .inv_i     (invert_i),
    .phase_i   (phase_sel_i),
    .len_o     (len_act),
    .inv_o     (inv_act),
    .phase_o   (phase_act),
    .pattern_o (pattern)
  );

  sfmt_serial #(
    .MAX_BITS (MAX_BITS)
  ) u_serial (
    .clk       (clk),
    .rst       (rst),
    .pattern_i (pattern),
    .bit_i     (bit_q),
    .len_i     (len_bits),
    .inv_i     (inv_act),
    .sdata_o   (sdata_o),
    .frame_o   (frame_o)
  );

  sfmt_fwd_clk #(
    .TICKS (TICKS_PER_BIT),
    .PH_W  (PH_W)
  ) u_fwd_clk (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_q),
    .phase_i (phase_act),
    .fclk_o  (fclk_o)
  );

  // R2: serial data holds for the whole bit period after its edge
  p_data_edge_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(tick_q) != '0) |-> $stable(sdata_o));

  // R1: reset drives every output low
  p_reset_low_r1: assert property (@(posedge clk)
    $past(rst) |-> (!sdata_o || !$past(rst, 2)) && (!frame_o || !$past(rst, 2)) && (!fclk_o || !$past(rst, 2)));

endmodule

// File: tb/serial_frame_fmt_tb.sv
module serial_frame_fmt_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] sample_i = '0;
  logic [1:0]  len_sel_i = 2'd2;
  logic        lsb_first_i = 1'b0;
  logic        invert_i = 1'b0;
  logic [2:0]  phase_sel_i = '0;
  logic        sdata_o, fclk_o, frame_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  serial_frame_fmt u_dut (
    .clk         (clk),
    .rst         (rst),
    .sample_i    (sample_i),
    .len_sel_i   (len_sel_i),
    .lsb_first_i (lsb_first_i),
    .invert_i    (invert_i),
    .phase_sel_i (phase_sel_i),
    .sdata_o     (sdata_o),
    .fclk_o      (fclk_o),
    .frame_o     (frame_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_bit(input logic [11:0] s, input int len, input bit lsb,
                                 input bit inv, input int b);
    int L, nd;
    bit v;
    L  = 8 + 2 * len;
    nd = (L < 12) ? L : 12;
    if (b >= nd)  v = 1'b0;
    else if (lsb) v = s[12 - nd + b];
    else          v = s[11 - b];
    return v ^ inv;
  endfunction

  task automatic wait_rise();
    logic p;
    do begin
      p = frame_o;
      @(negedge clk);
    end while (!(frame_o && !p));
  endtask

  task automatic set_inputs(input logic [11:0] s, input int len, input bit lsb,
                            input bit inv, input int ph);
    sample_i    = s;
    len_sel_i   = 2'(len);
    lsb_first_i = lsb;
    invert_i    = inv;
    phase_sel_i = 3'(ph);
  endtask

  // called at the negedge showing the first output cycle of the frame
  task automatic check_frame(input logic [11:0] s, input int len, input bit lsb,
                             input bit inv, input int ph, input bit mid, input string dtag);
    int L, off, t, b;
    int e_d, e_2, e_c, e_f, e_l;
    int a_d, x_d, a_2, x_2, a_c, x_c, a_f, x_f;
    bit ed, ec, ef;
    L = 8 + 2 * len;
    off = (3 + 2 * ph) % 12;
    e_d = 0; e_2 = 0; e_c = 0; e_f = 0; e_l = 0;
    a_d = 0; x_d = 0; a_2 = 0; x_2 = 0; a_c = 0; x_c = 0; a_f = 0; x_f = 0;
    for (int i = 0; i < 12 * L; i++) begin
      if (i > 0) @(negedge clk);
      t  = i % 12;
      b  = i / 12;
      ed = exp_bit(s, len, lsb, inv, b);
      ec = (((t - off + 12) % 12) < 6);
      ef = (b < L / 2);
      if (sdata_o !== ed) begin
        if (t == 0) begin if (e_d == 0) begin a_d = sdata_o; x_d = ed; end e_d++; end
        else        begin if (e_2 == 0) begin a_2 = sdata_o; x_2 = ed; end e_2++; end
      end
      if (fclk_o !== ec) begin if (e_c == 0) begin a_c = fclk_o; x_c = ec; end e_c++; end
      if (frame_o !== ef) begin if (e_f == 0) begin a_f = frame_o; x_f = ef; end e_f++; end
      if (mid && i > 6 * L && (sdata_o !== ed || fclk_o !== ec || frame_o !== ef)) e_l++;
      if (mid && i == 6 * L)
        set_inputs(~s, (len + 1) % 4, !lsb, !inv, (ph + 3) % 8);
    end
    chk(e_d == 0, dtag, a_d, x_d);
    chk(e_2 == 0, "R2", a_2, x_2);
    chk(e_c == 0, "R8", a_c, x_c);
    chk(e_f == 0, "R9", a_f, x_f);
    if (mid) chk(e_l == 0, "R10", e_l, 0);
    @(negedge clk);
    chk(frame_o === 1'b1, "R3", frame_o, 1);
  endtask

  task automatic run_frame(input logic [11:0] s, input int len, input bit lsb,
                           input bit inv, input int ph);
    string dtag;
    if (len == 3)  dtag = "R5";
    else if (inv)  dtag = "R7";
    else if (lsb)  dtag = "R6";
    else           dtag = "R4";
    wait_rise();
    set_inputs(s, len, lsb, inv, ph);
    wait_rise();
    check_frame(s, len, lsb, inv, ph, 1'b1, dtag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int combo;
    set_inputs(12'hA5C, 0, 1'b1, 1'b1, 5);
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    chk(sdata_o === 1'b0, "R1", sdata_o, 0);
    chk(fclk_o === 1'b0, "R1", fclk_o, 0);
    chk(frame_o === 1'b0, "R1", frame_o, 0);
    rst = 1'b0;
    @(negedge clk);
    // R1: first frame uses defaults and carries zeros
    check_frame(12'h000, 2, 1'b0, 1'b0, 0, 1'b0, "R1");

    // corner words
    run_frame(12'hFFF, 3, 1'b0, 1'b0, 0);
    run_frame(12'hFFF, 3, 1'b1, 1'b1, 0);
    run_frame(12'h800, 0, 1'b1, 1'b0, 2);
    run_frame(12'h001, 1, 1'b0, 1'b1, 4);
    run_frame(12'h000, 3, 1'b0, 1'b1, 7);

    // sweep of all length, order, inversion and phase settings
    combo = 0;
    for (int len = 0; len < 4; len++)
      for (int lsb = 0; lsb < 2; lsb++)
        for (int inv = 0; inv < 2; inv++)
          for (int ph = 0; ph < 8; ph++) begin
            run_frame(12'((combo * 2533 + 935) & 12'hFFF), len, lsb[0], inv[0], ph);
            combo++;
          end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule